// File: doc/BRIEF.md
# Learning-Automaton Shared Bus Arbiter

This block decides, once per time slot, which of `N_PORTS` input ports may drive a shared bus. It does not use request lines. Each port holds a learned credit count, measured in units of 1/`K_MAX`. Each unit of credit is one entry in a compact owner table. To grant a slot, the block draws one table entry uniformly at random and grants that entry's owner. The chance of a grant is therefore proportional to the port's credit. When the table is empty, the block draws a port uniformly from all ports.

The only feedback is whether the bus was busy in the granted slot. A busy slot adds one credit to the granted port by appending a table entry. An idle slot removes one credit by moving the last entry into the drawn position. Each update is a single table write, whatever the values of `N_PORTS` and `K_MAX`.

Two variants are selected by `mode_improved`:
- **Basic:** credit runs from 0 to `K_MAX`, and the table starts empty.
- **Improved:** credit runs from 1 to `K_MAX`, and the table starts with one entry per port.

A synchronous `reinit` rebuilds all state. The system must pulse it whenever a port is added while the system is running. Grant is a plain strobe with no back-pressure: the bus side cannot stall it, and the bus status must be presented in the cycle the strobe is high.

Top module: `la_bus_arbiter`

## Requirements
- R1: At `rst` or `reinit`, the block samples `mode_improved` and initialises its state for that mode.
  - Basic (0): the table is empty and every credit is 0.
  - Improved (1): the table holds `N_PORTS` entries, entry i owned by port i, and every credit is 1.
  - In both modes the random generator is reloaded with `SEED` and `grant_valid` is 0 in the following cycle.
- R2: A `slot_start` sampled high while `grant_valid` is low and `reinit` is low is accepted. `grant_valid` is then high for exactly the next cycle, together with `grant_port`.
- R3: When an accepted slot finds the table empty, the granted port is `(r * N_PORTS) >> 32`, where r is the 32-bit generator state.
- R4: When the table holds S > 0 entries, the drawn entry index is `(r * S) >> 32`, and the granted port is the owner of that entry.
- R5: If `bus_busy` is 1 in the cycle `grant_valid` is high and the granted port's credit is below `K_MAX`, then:
  - an entry owned by that port is written at index S;
  - S grows by one;
  - the port's credit grows by one.
  Otherwise no change is made.
- R6: If `bus_busy` is 0 in that cycle and the granted port's credit is above the mode minimum (0 basic, 1 improved), then:
  - the drawn entry is overwritten with entry S-1;
  - S shrinks by one;
  - the credit shrinks by one.
  Otherwise no change is made.
- R7: The generator advances only on an accepted slot, after its current value r has been used. The next value is `(r << 1) ^ (r[31] ? 32'h0040_0007 : 0)`.
- R8: A `slot_start` that is high while `grant_valid` is high is ignored. It produces no grant in the next cycle and does not advance the generator.
- R9: `reinit` in the same cycle as a pending update wins. The update is dropped, and `grant_valid` is 0 in the next cycle.
- R10: A change of `mode_improved` has no effect until the next `rst` or `reinit`.
- R11: Whenever `grant_valid` is high, `grant_port` is below `N_PORTS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; initialises like `reinit` |
| reinit | input | 1 | Synchronous rebuild of all arbitration state |
| mode_improved | input | 1 | 0 = basic variant, 1 = improved variant; sampled at `rst`/`reinit` |
| slot_start | input | 1 | Pulse that opens a time slot |
| bus_busy | input | 1 | 1 if the granted port used the bus; sampled while `grant_valid` is high |
| grant_valid | output | 1 | One-cycle strobe qualifying `grant_port` |
| grant_port | output | $clog2(N_PORTS) | Index of the granted port |

## Verification
Two events can fall in one cycle: the credit update for a slot and a new `slot_start`, and the credit update and `reinit`.

The bench provokes the first by holding `slot_start` through the grant cycle. It judges the result by the absence of a grant in the next cycle and by later grants that still match a model whose generator did not advance.

For the second, it raises `reinit` with `bus_busy` high during a grant. It then checks that `grant_valid` drops and that the grants that follow match a freshly initialised model rather than an incremented one.

// File: rtl/la_arb_pkg.sv
package la_arb_pkg;
  localparam logic [31:0] LFSR_TAPS = 32'h0040_0007;

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {s[30:0], 1'b0} ^ (s[31] ? LFSR_TAPS : 32'h0);
  endfunction
endpackage

// File: rtl/la_lfsr.sv
module la_lfsr #(
  parameter logic [31:0] SEED = 32'h5EED_1234
) (
  input  logic        clk,
  input  logic        init,
  input  logic        adv,
  output logic [31:0] value
);
  import la_arb_pkg::*;

  always_ff @(posedge clk) begin
    if (init)     value <= SEED;
    else if (adv) value <= lfsr_step(value);
  end
endmodule

// File: rtl/la_scale.sv
module la_scale #(
  parameter int W = 6
) (
  input  logic [31:0]  rnd,
  input  logic [W-1:0] span,
  output logic [W-1:0] pick
);
  logic [31+W:0] prod;

  always_comb begin
    prod = {{W{1'b0}}, rnd} * {32'b0, span};
    pick = prod[32 +: W];
  end
endmodule

// File: rtl/la_credit_table.sv
module la_credit_table #(
  parameter int N_PORTS = 4,
  parameter int K_MAX   = 8,
  localparam int DEPTH  = N_PORTS * K_MAX,
  localparam int PW     = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SW     = $clog2(DEPTH + 1),
  localparam int CW     = $clog2(K_MAX + 1)
) (
  input  logic          clk,
  input  logic          init,
  input  logic          init_improved,
  input  logic          mode_q,
  input  logic          upd_en,
  input  logic          upd_busy,
  input  logic [PW-1:0] upd_port,
  input  logic [SW-1:0] upd_idx,
  input  logic [SW-1:0] rd_idx,
  output logic [PW-1:0] rd_port,
  output logic [SW-1:0] size
);
  logic [PW-1:0] owner [DEPTH];
  logic [CW-1:0] credit [N_PORTS];
  logic [CW-1:0] floor_v;
  logic [SW-1:0] last;
  logic          grow, shrink;

  always_comb begin
    floor_v = mode_q ? CW'(1) : CW'(0);
    last    = size - SW'(1);
    grow    = upd_en &&  upd_busy && (credit[upd_port] < CW'(K_MAX));
    shrink  = upd_en && !upd_busy && (credit[upd_port] > floor_v);
    rd_port = owner[rd_idx[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (init) begin
      for (int i = 0; i < DEPTH; i++)
        owner[i] <= (init_improved && i < N_PORTS) ? PW'(i) : '0;
      for (int p = 0; p < N_PORTS; p++)
        credit[p] <= init_improved ? CW'(1) : CW'(0);
      size <= init_improved ? SW'(N_PORTS) : '0;
    end else if (grow) begin
      owner[size[AW-1:0]] <= upd_port;
      size                <= size + SW'(1);
      credit[upd_port]    <= credit[upd_port] + CW'(1);
    end else if (shrink) begin
      owner[upd_idx[AW-1:0]] <= owner[last[AW-1:0]];
      size                   <= last;
      credit[upd_port]       <= credit[upd_port] - CW'(1);
    end
  end
endmodule

// File: rtl/la_bus_arbiter.sv
module la_bus_arbiter #(
  parameter int          N_PORTS = 4,
  parameter int          K_MAX   = 8,
  parameter logic [31:0] SEED    = 32'h5EED_1234,
  localparam int DEPTH = N_PORTS * K_MAX,
  localparam int PW    = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int SW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reinit,
  input  logic          mode_improved,
  input  logic          slot_start,
  input  logic          bus_busy,
  output logic          grant_valid,
  output logic [PW-1:0] grant_port
);
  logic          init, accept, mode_q;
  logic [31:0]   rnd;
  logic [SW-1:0] size, idx_tab, idx_all, idx_q;
  logic [PW-1:0] tab_port, pick_port;

  assign init   = rst || reinit;
  assign accept = slot_start && !grant_valid && !init;

  la_lfsr #(.SEED(SEED)) u_lfsr (
    .clk(clk), .init(init), .adv(accept), .value(rnd)
  );

  la_scale #(.W(SW)) u_scale_tab (.rnd(rnd), .span(size), .pick(idx_tab));
  la_scale #(.W(SW)) u_scale_all (.rnd(rnd), .span(SW'(N_PORTS)), .pick(idx_all));

  la_credit_table #(.N_PORTS(N_PORTS), .K_MAX(K_MAX)) u_table (
    .clk(clk), .init(init), .init_improved(mode_improved), .mode_q(mode_q),
    .upd_en(grant_valid && !init), .upd_busy(bus_busy),
    .upd_port(grant_port), .upd_idx(idx_q),
    .rd_idx(idx_tab), .rd_port(tab_port), .size(size)
  );

  assign pick_port = (size == '0) ? idx_all[PW-1:0] : tab_port;

  always_ff @(posedge clk) begin
    if (init) begin
      mode_q      <= mode_improved;
      grant_valid <= 1'b0;
      grant_port  <= '0;
      idx_q       <= '0;
    end else begin
      grant_valid <= accept;
      if (accept) begin
        grant_port <= pick_port;
        idx_q      <= idx_tab;
      end
    end
  end
endmodule

// File: rtl/la_bus_arbiter_chk.sv
module la_bus_arbiter_chk #(
  parameter int N_PORTS = 4,
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          reinit,
  input logic          slot_start,
  input logic          grant_valid,
  input logic [PW-1:0] grant_port
);
  p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    grant_valid |=> !grant_valid);
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (slot_start && !grant_valid && !reinit) |=> grant_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !reinit) |=> $stable(grant_port));
  p_reinit_r9: assert property (@(posedge clk) disable iff (rst)
    reinit |=> !grant_valid);
  p_range_r11: assert property (@(posedge clk) disable iff (rst)
    grant_valid |-> (32'(grant_port) < N_PORTS));
endmodule

bind la_bus_arbiter la_bus_arbiter_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk(clk), .rst(rst), .reinit(reinit), .slot_start(slot_start),
  .grant_valid(grant_valid), .grant_port(grant_port)
);

// File: tb/la_bus_arbiter_tb.sv
module la_bus_arbiter_tb;
  localparam int NP = 4;
  localparam int KM = 8;
  localparam logic [31:0] SEED = 32'h5EED_1234;

  logic clk = 1'b0;
  logic rst = 1'b1, reinit = 1'b0, mode_improved = 1'b0;
  logic slot_start = 1'b0, bus_busy = 1'b0;
  logic grant_valid;
  logic [1:0] grant_port;

  la_bus_arbiter #(.N_PORTS(NP), .K_MAX(KM), .SEED(SEED)) u_dut (
    .clk(clk), .rst(rst), .reinit(reinit), .mode_improved(mode_improved),
    .slot_start(slot_start), .bus_busy(bus_busy),
    .grant_valid(grant_valid), .grant_port(grant_port)
  );

  always #5 clk = ~clk;

  int total = 0, failed = 0;
  int m_own [NP*KM];
  int m_cnt [NP];
  int m_size, m_mode;
  logic [31:0] m_rnd;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_init(input int mode);
    m_mode = mode;
    m_rnd  = SEED;
    for (int i = 0; i < NP*KM; i++) m_own[i] = (mode == 1 && i < NP) ? i : 0;
    for (int p = 0; p < NP; p++) m_cnt[p] = mode;
    m_size = (mode == 1) ? NP : 0;
  endtask

  function automatic int scale(input logic [31:0] r, input int span);
    logic [63:0] prod;
    prod = {32'b0, r} * 64'(span);
    return int'(prod >> 32);
  endfunction

  // busy: bus status; hold: keep slot_start high through grant; rmid: reinit in grant cycle
  task automatic do_slot(input bit busy, input bit hold, input bit rmid);
    int idx, exp, lo;
    if (m_size == 0) begin idx = 0; exp = scale(m_rnd, NP); end
    else begin idx = scale(m_rnd, m_size); exp = m_own[idx]; end
    m_rnd = {m_rnd[30:0], 1'b0} ^ (m_rnd[31] ? 32'h0040_0007 : 32'h0); // R7
    @(negedge clk); slot_start = 1'b1;
    @(negedge clk);
    slot_start = hold; bus_busy = busy; reinit = rmid;
    chk(grant_valid === 1'b1, "R2 grant strobe", int'(grant_valid), 1);
    chk(int'(grant_port) == exp, (m_size == 0) ? "R3 uniform pick" : "R4 table pick",
        int'(grant_port), exp);
    @(negedge clk);
    slot_start = 1'b0; reinit = 1'b0;
    chk(grant_valid === 1'b0,
        rmid ? "R9 reinit clears" : (hold ? "R8 start ignored" : "R2 one-cycle strobe"),
        int'(grant_valid), 0);
    if (rmid) model_init(int'(mode_improved));
    else begin
      lo = m_mode;
      if (busy && m_cnt[exp] < KM) begin          // R5
        m_own[m_size] = exp; m_size++; m_cnt[exp]++;
      end else if (!busy && m_cnt[exp] > lo) begin // R6
        m_own[idx] = m_own[m_size-1]; m_size--; m_cnt[exp]--;
      end
    end
  endtask

  function automatic bit burst(input int s, input int p);
    return ((s / (5 + 3*p)) + p) % 2 == 0;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    model_init(0);
    repeat (3) @(negedge clk);
    chk(grant_valid === 1'b0, "R1 reset idle", int'(grant_valid), 0);
    rst = 1'b0;
    // basic mode: empty table, uniform path (R3), then learning (R5, R6)
    for (int s = 0; s < 40; s++)  do_slot(1'b0, 1'b0, 1'b0);
    for (int s = 0; s < 60; s++)  do_slot(m_size % 2 == 0, 1'b0, 1'b0);
    for (int s = 0; s < 250; s++) do_slot(burst(s, s % NP), 1'b0, 1'b0);
    for (int s = 0; s < 80; s++)  do_slot(1'b1, 1'b0, 1'b0);  // R5 saturation
    do_slot(1'b1, 1'b1, 1'b0);                                // R8
    for (int s = 0; s < 20; s++)  do_slot(s % 3 == 0, 1'b0, 1'b0);
    // R10: mode input changes, basic floor stays until reinit
    mode_improved = 1'b1;
    for (int s = 0; s < 200; s++) do_slot(1'b0, 1'b0, 1'b0);  // drains to empty
    for (int s = 0; s < 10; s++)  do_slot(1'b0, 1'b0, 1'b0);
    // R9 + R1: reinit collides with a busy update, improved state from seed
    do_slot(1'b1, 1'b0, 1'b1);
    for (int s = 0; s < 300; s++) do_slot(burst(s + 7, s % NP), 1'b0, 1'b0);
    for (int s = 0; s < 80; s++)  do_slot(1'b1, 1'b0, 1'b0);
    for (int s = 0; s < 200; s++) do_slot(1'b0, 1'b0, 1'b0);  // R6 floor at 1
    do_slot(1'b0, 1'b1, 1'b0);                                // R8
    // R1: back to basic through reinit alone
    mode_improved = 1'b0;
    do_slot(1'b0, 1'b0, 1'b1);
    for (int s = 0; s < 100; s++) do_slot(burst(s, (s * 3) % NP), 1'b0, 1'b0);
    summary();
  end
endmodule